// File: doc/BRIEF.md
# Parallel-Port Burst Transfer Engine

This block runs a whole burst of bytes between a local byte buffer and an adapter's data register across a parallel port. It first selects the adapter register with a fixed strobe pattern. It then moves the bytes in one of six transfer modes and closes the burst with the control writes that the mode requires. The port is seen as a stream of one-cycle operations. Each cycle carries at most one control write, data write, status read, data read, EPP-style write or EPP-style read. An external port model turns these operations into pin activity. Wider EPP word cycles are reduced to single byte steps.

A host pulses `start` while the engine is idle. With the pulse it presents a mode (0 to 5), a direction (0 reads from the adapter, 1 writes to it) and a byte count. During a read the engine stores byte k at buffer address k. During a write it fetches byte k from buffer address k through a combinational read port. When the burst ends, `done` pulses for one cycle. An unsupported mode is reported through `err` together with `done`, and no port operation takes place.

Top module: `pport_burst`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `err` and `buf_we` are low and `pp_op` is 0 (no operation).
- R2: `pp_op` codes: 0 none, 1 control write, 2 data write, 3 status read, 4 data read, 5 EPP write, 6 EPP read; `pp_wdata` carries the value for codes 1, 2 and 5 and is 0 otherwise. Every non-empty burst opens with control 0x04, data write of the select byte, then control 0x0C, 0x0E, 0x0E, 0x0C, 0x04, 0x04, 0x04. The select byte is 0x08 for a mode-0 read and for writes in modes 0 to 2, 0xC8 for a mode-1 read and for writes in modes 3 to 5, and 0x88 for reads in modes 2 to 5.
- R3: A mode-0 read takes each byte as control 0x06, status read, control 0x04, status read. Bits 7:4 of the first status read give bits 3:0 of the byte, and bits 7:4 of the second give bits 7:4. The burst closes with control 0x04.
- R4: A mode-1 read writes data 0xFF after the select pattern. Each byte k is a control write of 0xA6 (k even) or 0xA4 (k odd) followed by a data read. The burst closes with control 0xAC, 0xA4, 0x04.
- R5: A mode-2 read takes one EPP read per byte and closes with control 0xAC, 0xA4, 0x04.
- R6: Reads in modes 3 to 5 issue control 0xAC then 0xA4 just before the byte that leaves two bytes still to read. If the count is below 2, this pair comes before the first byte. The remaining EPP reads follow, then control 0x04.
- R7: Writes in modes 0 to 2 issue control 0x05 after the select pattern. Each byte is a data write of the byte followed by control 0x07 and then 0x05. The burst closes with control 0x04.
- R8: Writes in modes 3 to 5 issue control 0x05 after the select pattern, then one EPP write per byte, then control 0x04.
- R9: Read byte k is written to buffer address k in the cycle after the port read that completes it. Write byte k is taken from buffer address k.
- R10: A start with count 0 and a valid mode gives `done` in the next cycle with `err` low and no port operation.
- R11: A start with a mode value of 6 or 7 gives `done` and `err` together in the next cycle, with no port operation.
- R12: A start pulse while a burst is running is ignored, and the running burst's sequence is unchanged.
- R13: `done` is high for exactly one cycle, the cycle after the final control write of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (sampled while idle) |
| mode | input | 3 | Transfer mode, 0 to 5 valid |
| dir | input | 1 | 0 read from adapter, 1 write to adapter |
| count | input | CNT_W | Bytes in the burst |
| busy | output | 1 | Burst in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported mode, valid with done |
| pp_op | output | 3 | Port operation this cycle |
| pp_wdata | output | 8 | Value for control, data or EPP write |
| pp_rdata | input | 8 | Port read value, sampled at the end of a read cycle |
| buf_raddr | output | CNT_W | Buffer read address (write bursts) |
| buf_rdata | input | 8 | Buffer byte at buf_raddr |
| buf_we | output | 1 | Buffer write strobe (read bursts) |
| buf_waddr | output | CNT_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write byte |

## Verification
The bench targets where the closing 0xAC/0xA4 pair goes in the EPP read modes. Counts of 1, 2 and 5 are used there. A design that placed the pair at the end, or counted the two-byte margin wrongly, would emit EPP reads in the wrong order relative to the pair. Mode-0 nibble assembly is fed status values whose lower nibbles differ, so a design that merged the wrong nibbles or swapped them stores wrong buffer bytes. Zero counts, illegal modes and a second start during a burst are each checked. A design that got these wrong would emit port activity, miss the error flag or corrupt the running sequence.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CTRL = 3'd1,
    OP_DATA = 3'd2,
    OP_STAT = 3'd3,
    OP_DRD  = 3'd4,
    OP_EPPW = 3'd5,
    OP_EPPR = 3'd6
  } ppb_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_PRE, S_BYTE, S_TERM, S_FIN, S_DONE
  } ppb_state_e;

  typedef struct packed {
    ppb_op_e    op;
    logic [7:0] val;
  } ppb_cmd_t;

  localparam logic [2:0] MAX_MODE  = 3'd5;
  localparam int         SEL_STEPS = 9;

  // register-select byte for a given mode and direction
  function automatic logic [7:0] sel_byte(input logic [2:0] m, input logic wr);
    if (wr) return (m <= 3'd2) ? 8'h08 : 8'hC8;
    if (m == 3'd0) return 8'h08;
    if (m == 3'd1) return 8'hC8;
    return 8'h88;
  endfunction

endpackage

// File: rtl/ppb_addr_seq.sv
`timescale 1ns/1ps
module ppb_addr_seq
  import ppb_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step,
  input  logic [7:0]        sel,
  output ppb_cmd_t          cmd,
  output logic              last
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEL_STEPS - 1);

  always_comb begin
    cmd = '{op: OP_CTRL, val: 8'h04};
    case (step)
      STEP_W'(1): cmd = '{op: OP_DATA, val: sel};
      STEP_W'(2): cmd.val = 8'h0C;
      STEP_W'(3): cmd.val = 8'h0E;
      STEP_W'(4): cmd.val = 8'h0E;
      STEP_W'(5): cmd.val = 8'h0C;
      default:    cmd.val = 8'h04;
    endcase
  end

  assign last = (step == LAST_STEP);

endmodule

// File: rtl/ppb_assemble.sv
`timescale 1ns/1ps
module ppb_assemble
  import ppb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_lo,
  input  logic             cap_byte,
  input  logic             nib_mode,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       pp_rdata,
  input  ppb_op_e          pp_op,
  output logic             buf_we,
  output logic [CNT_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata
);

  logic [3:0]       lo_q;
  logic [7:0]       byte_d;
  logic             we_q;
  logic [CNT_W-1:0] waddr_q;
  logic [7:0]       wdata_q;

  always_comb begin
    byte_d = nib_mode ? {pp_rdata[7:4], lo_q} : pp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= cap_byte;
      if (cap_lo) lo_q <= pp_rdata[7:4];
      if (cap_byte) begin
        waddr_q <= idx;
        wdata_q <= byte_d;
      end
    end
  end

  assign buf_we    = we_q;
  assign buf_waddr = waddr_q;
  assign buf_wdata = wdata_q;

  AST_BUF_WE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ($past(pp_op) == OP_STAT || $past(pp_op) == OP_DRD || $past(pp_op) == OP_EPPR)) // R9
    else $error("buffer write without a completing port read");

endmodule

// File: rtl/ppb_ctrl.sv
`timescale 1ns/1ps
module ppb_ctrl
  import ppb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode_i,
  input  logic              dir_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [7:0]        buf_rdata,
  input  ppb_cmd_t          sel_cmd,
  input  logic              sel_last,
  output logic [STEP_W-1:0] sel_step,
  output logic [7:0]        sel_val,
  output ppb_cmd_t          cmd_o,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cap_lo,
  output logic              cap_byte,
  output logic              nib_mode,
  output logic [CNT_W-1:0]  idx_o
);

  localparam logic [CNT_W-1:0] TERM_MARGIN = CNT_W'(2);

  ppb_state_e        state_q, state_d;
  logic [STEP_W-1:0] sub_q, sub_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [2:0]        mode_q;
  logic              dir_q;
  logic              term_q, term_d;
  logic              err_q, err_d;
  logic              ld;
  logic              rd;
  logic              pre_need;
  logic [STEP_W-1:0] byte_last;
  logic [CNT_W-1:0]  rem_dec;

  assign rd       = ~dir_q;
  assign pre_need = ~rd | (mode_q == 3'd1);
  assign rem_dec  = rem_q - 1'b1;

  always_comb begin
    if (rd) begin
      if (mode_q == 3'd0)      byte_last = STEP_W'(3);
      else if (mode_q == 3'd1) byte_last = STEP_W'(1);
      else                     byte_last = '0;
    end else begin
      byte_last = (mode_q <= 3'd2) ? STEP_W'(2) : '0;
    end
  end

  // what follows once `r` bytes remain and the close pair state is `t`
  function automatic ppb_state_e pick(input logic [CNT_W-1:0] r, input logic t,
                                      input logic rdd, input logic [2:0] m);
    if (r == '0) return (rdd && m != 3'd0 && !t) ? S_TERM : S_FIN;
    if (rdd && m >= 3'd3 && !t && r <= TERM_MARGIN) return S_TERM;
    return S_BYTE;
  endfunction

  // next-state
  always_comb begin
    state_d = state_q;
    sub_d   = sub_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    term_d  = term_q;
    err_d   = err_q;
    ld      = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        ld     = 1'b1;
        sub_d  = '0;
        idx_d  = '0;
        rem_d  = count_i;
        term_d = 1'b0;
        err_d  = (mode_i > MAX_MODE);
        if (mode_i > MAX_MODE || count_i == '0) state_d = S_DONE;
        else                                    state_d = S_ADDR;
      end
      S_ADDR: begin
        if (sel_last) begin
          sub_d   = '0;
          state_d = pre_need ? S_PRE : pick(rem_q, term_q, rd, mode_q);
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      S_PRE: begin
        sub_d   = '0;
        state_d = pick(rem_q, term_q, rd, mode_q);
      end
      S_BYTE: begin
        if (sub_q == byte_last) begin
          sub_d   = '0;
          idx_d   = idx_q + 1'b1;
          rem_d   = rem_dec;
          state_d = pick(rem_dec, term_q, rd, mode_q);
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      S_TERM: begin
        if (sub_q == STEP_W'(1)) begin
          sub_d   = '0;
          term_d  = 1'b1;
          state_d = pick(rem_q, 1'b1, rd, mode_q);
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      S_FIN:   state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sub_q   <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      term_q  <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      term_q  <= term_d;
      err_q   <= err_d;
      if (ld) begin
        mode_q <= mode_i;
        dir_q  <= dir_i;
      end
    end
  end

  // port command for this cycle
  always_comb begin
    cmd_o = '{op: OP_NONE, val: 8'h00};
    case (state_q)
      S_ADDR: cmd_o = sel_cmd;
      S_PRE:  cmd_o = rd ? '{op: OP_DATA, val: 8'hFF} : '{op: OP_CTRL, val: 8'h05};
      S_BYTE: begin
        if (rd) begin
          if (mode_q == 3'd0) begin
            case (sub_q)
              STEP_W'(0): cmd_o = '{op: OP_CTRL, val: 8'h06};
              STEP_W'(2): cmd_o = '{op: OP_CTRL, val: 8'h04};
              default:    cmd_o = '{op: OP_STAT, val: 8'h00};
            endcase
          end else if (mode_q == 3'd1) begin
            if (sub_q == '0) cmd_o = '{op: OP_CTRL, val: idx_q[0] ? 8'hA4 : 8'hA6};
            else             cmd_o = '{op: OP_DRD,  val: 8'h00};
          end else begin
            cmd_o = '{op: OP_EPPR, val: 8'h00};
          end
        end else if (mode_q <= 3'd2) begin
          case (sub_q)
            STEP_W'(0): cmd_o = '{op: OP_DATA, val: buf_rdata};
            STEP_W'(1): cmd_o = '{op: OP_CTRL, val: 8'h07};
            default:    cmd_o = '{op: OP_CTRL, val: 8'h05};
          endcase
        end else begin
          cmd_o = '{op: OP_EPPW, val: buf_rdata};
        end
      end
      S_TERM: cmd_o = '{op: OP_CTRL, val: (sub_q == '0) ? 8'hAC : 8'hA4};
      S_FIN:  cmd_o = '{op: OP_CTRL, val: 8'h04};
      default: ;
    endcase
  end

  assign sel_step = sub_q;
  assign sel_val  = sel_byte(mode_q, dir_q);
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign err      = done & err_q;
  assign cap_lo   = (state_q == S_BYTE) && rd && (mode_q == 3'd0) && (sub_q == STEP_W'(1));
  assign cap_byte = (state_q == S_BYTE) && rd && (sub_q == byte_last);
  assign nib_mode = (mode_q == 3'd0);
  assign idx_o    = idx_q;

  AST_FIRST_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start && mode_i <= MAX_MODE && count_i != '0)
      |=> (cmd_o.op == OP_CTRL && cmd_o.val == 8'h04)) // R2
    else $error("burst did not open with control 0x04");

  AST_CLOSE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o.op == OP_CTRL && cmd_o.val == 8'hAC) |=> (cmd_o.op == OP_CTRL && cmd_o.val == 8'hA4)) // R6
    else $error("0xAC not followed by 0xA4");

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start && mode_i <= MAX_MODE && count_i == '0)
      |=> (done && !err && cmd_o.op == OP_NONE)) // R10
    else $error("zero count mishandled");

  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start && mode_i > MAX_MODE) |=> (done && err && cmd_o.op == OP_NONE)) // R11
    else $error("illegal mode not flagged");

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (mode_q == $past(mode_q) && dir_q == $past(dir_q))) // R12
    else $error("start accepted while busy");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) // R13
    else $error("done longer than one cycle");

endmodule

// File: rtl/pport_burst.sv
`timescale 1ns/1ps
module pport_burst
  import ppb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic             dir,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       pp_op,
  output logic [7:0]       pp_wdata,
  input  logic [7:0]       pp_rdata,
  output logic [CNT_W-1:0] buf_raddr,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [CNT_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata
);

  localparam int STEP_W = $clog2(SEL_STEPS);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  ppb_cmd_t          sel_cmd, cmd;
  logic              sel_last;
  logic [STEP_W-1:0] sel_step;
  logic [7:0]        sel_val;
  logic              cap_lo, cap_byte, nib_mode;
  logic [CNT_W-1:0]  idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ppb_addr_seq #(.STEP_W(STEP_W)) u_sel (
    .step (sel_step),
    .sel  (sel_val),
    .cmd  (sel_cmd),
    .last (sel_last)
  );

  ppb_ctrl #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .mode_i    (mode),
    .dir_i     (dir),
    .count_i   (count),
    .buf_rdata (buf_rdata),
    .sel_cmd   (sel_cmd),
    .sel_last  (sel_last),
    .sel_step  (sel_step),
    .sel_val   (sel_val),
    .cmd_o     (cmd),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cap_lo    (cap_lo),
    .cap_byte  (cap_byte),
    .nib_mode  (nib_mode),
    .idx_o     (idx)
  );

  ppb_assemble #(.CNT_W(CNT_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cap_lo    (cap_lo),
    .cap_byte  (cap_byte),
    .nib_mode  (nib_mode),
    .idx       (idx),
    .pp_rdata  (pp_rdata),
    .pp_op     (cmd.op),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata)
  );

  assign pp_op     = cmd.op;
  assign pp_wdata  = cmd.val;
  assign buf_raddr = idx;

endmodule

// File: tb/tb_pport_burst.sv
`timescale 1ns/1ps
module tb_pport_burst;

  localparam int CNT_W = 16;

  logic             clk, rst_n, start, dir;
  logic [2:0]       mode;
  logic [CNT_W-1:0] count;
  logic             busy, done, err, buf_we;
  logic [2:0]       pp_op;
  logic [7:0]       pp_wdata, pp_rdata, buf_rdata, buf_wdata;
  logic [CNT_W-1:0] buf_raddr, buf_waddr;

  pport_burst #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir), .count(count),
    .busy(busy), .done(done), .err(err), .pp_op(pp_op), .pp_wdata(pp_wdata),
    .pp_rdata(pp_rdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int last_op_cyc = 0;
  int mp = 0;
  logic [7:0] last_ctrl = 8'h00;
  logic [7:0] src [0:63];
  logic [7:0] wsrc [0:63];
  logic [10:0] q_exp [$];
  string       q_tag [$];
  logic [23:0] bw_exp [$];

  assign buf_rdata = wsrc[buf_raddr[5:0]];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: port operations, adapter model and buffer writes
  always @(negedge clk) begin
    if (rst_n && pp_op != 3'd0) begin
      last_op_cyc = cyc;
      if (q_exp.size() == 0) begin
        chk(1'b0, "R2", "unexpected port op", {pp_op, pp_wdata}, 0);
      end else begin
        logic [10:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk({pp_op, pp_wdata} == e, t, "port op {op,val}", {pp_op, pp_wdata}, e);
      end
      case (pp_op)
        3'd1: last_ctrl = pp_wdata;
        3'd3: begin
          if (last_ctrl == 8'h06) pp_rdata = {src[mp][3:0], 4'h5};
          else begin
            pp_rdata = {src[mp][7:4], 4'hA};
            mp++;
          end
        end
        3'd4, 3'd6: begin
          pp_rdata = src[mp];
          mp++;
        end
        default: ;
      endcase
    end
    if (rst_n && buf_we) begin
      if (bw_exp.size() == 0) begin
        chk(1'b0, "R9", "unexpected buffer write", {buf_waddr, buf_wdata}, 0);
      end else begin
        logic [23:0] b;
        b = bw_exp.pop_front();
        chk({buf_waddr, buf_wdata} == b, "R9", "buffer write {addr,data}", {buf_waddr, buf_wdata}, b);
      end
    end
  end

  function automatic void px(input logic [2:0] op, input logic [7:0] v, input string t);
    q_exp.push_back({op, v});
    q_tag.push_back(t);
  endfunction

  function automatic void psel(input logic [7:0] a);
    px(3'd1, 8'h04, "R2"); px(3'd2, a, "R2");
    px(3'd1, 8'h0C, "R2"); px(3'd1, 8'h0E, "R2"); px(3'd1, 8'h0E, "R2");
    px(3'd1, 8'h0C, "R2"); px(3'd1, 8'h04, "R2"); px(3'd1, 8'h04, "R2"); px(3'd1, 8'h04, "R2");
  endfunction

  // driver: builds the expected stream, then runs one burst
  task automatic run(input int m, input bit wr, input int n, input bit poke);
    int sc, to;
    bit t;
    t = 1'b0;
    if (m <= 5 && n > 0) begin
      if (wr) begin
        psel((m <= 2) ? 8'h08 : 8'hC8);
        px(3'd1, 8'h05, (m <= 2) ? "R7" : "R8");
        for (int k = 0; k < n; k++) begin
          if (m <= 2) begin
            px(3'd2, wsrc[k], "R7"); px(3'd1, 8'h07, "R7"); px(3'd1, 8'h05, "R7");
          end else px(3'd5, wsrc[k], "R8");
        end
        px(3'd1, 8'h04, (m <= 2) ? "R7" : "R8");
      end else begin
        psel((m == 0) ? 8'h08 : (m == 1) ? 8'hC8 : 8'h88);
        if (m == 1) px(3'd2, 8'hFF, "R4");
        for (int k = 0; k < n; k++) begin
          if (m == 0) begin
            px(3'd1, 8'h06, "R3"); px(3'd3, 8'h00, "R3");
            px(3'd1, 8'h04, "R3"); px(3'd3, 8'h00, "R3");
          end else if (m == 1) begin
            px(3'd1, (k % 2 == 0) ? 8'hA6 : 8'hA4, "R4"); px(3'd4, 8'h00, "R4");
          end else begin
            if (m >= 3 && !t && n - k <= 2) begin
              px(3'd1, 8'hAC, "R6"); px(3'd1, 8'hA4, "R6"); t = 1'b1;
            end
            px(3'd6, 8'h00, (m == 2) ? "R5" : "R6");
          end
          bw_exp.push_back({k[15:0], src[k]});
        end
        if (m != 0 && !t) begin
          px(3'd1, 8'hAC, (m == 1) ? "R4" : (m == 2) ? "R5" : "R6");
          px(3'd1, 8'hA4, (m == 1) ? "R4" : (m == 2) ? "R5" : "R6");
        end
        px(3'd1, 8'h04, (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6");
      end
    end
    mp = 0;
    @(negedge clk);
    mode = m[2:0]; dir = wr; count = n[15:0]; start = 1'b1; sc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      mode = 3'd0; dir = ~wr; count = 16'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      mode = m[2:0]; dir = wr; count = n[15:0];
    end
    to = 0;
    while (!done && to < 5000) begin
      @(negedge clk);
      to++;
    end
    chk(done == 1'b1, "R13", "done seen", done, 1);
    chk(err == (m > 5), (m > 5) ? "R11" : "R10", "err with done", err, (m > 5));
    if (m > 5 || n == 0)
      chk(cyc == sc + 1, (m > 5) ? "R11" : "R10", "done cycle after start", cyc - sc, 1);
    else
      chk(cyc == last_op_cyc + 1, "R13", "done after final control", cyc - last_op_cyc, 1);
    @(negedge clk);
    chk(done == 1'b0, "R13", "done one cycle", done, 0);
    chk(q_exp.size() == 0, poke ? "R12" : "R2", "ops left over", q_exp.size(), 0);
    chk(bw_exp.size() == 0, "R9", "buffer writes left over", bw_exp.size(), 0);
    q_exp.delete(); q_tag.delete(); bw_exp.delete();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      src[i]  = 8'(i * 37 + 11);
      wsrc[i] = ~8'(i * 13 + 5);
    end
    rst_n = 1'b0; start = 1'b0; mode = '0; dir = 1'b0; count = '0; pp_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !buf_we && pp_op == 3'd0, "R1", "reset state",
        {busy, done, err, buf_we, pp_op}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && pp_op == 3'd0, "R1", "idle after reset", {busy, pp_op}, 0);
    run(0, 1'b0, 3, 1'b0);   // R3
    run(1, 1'b0, 5, 1'b0);   // R4
    run(2, 1'b0, 2, 1'b0);   // R5
    run(3, 1'b0, 5, 1'b0);   // R6 pair in the middle
    run(4, 1'b0, 1, 1'b0);   // R6 pair before the only byte
    run(5, 1'b0, 2, 1'b0);   // R6 pair before the first of two
    run(1, 1'b1, 3, 1'b0);   // R7
    run(0, 1'b1, 2, 1'b0);   // R7
    run(5, 1'b1, 3, 1'b0);   // R8
    run(2, 1'b0, 0, 1'b0);   // R10
    run(6, 1'b0, 4, 1'b0);   // R11
    run(7, 1'b1, 4, 1'b0);   // R11
    run(3, 1'b0, 6, 1'b1);   // R12 start pulse during the burst
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    failures++;
    $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule